// File: doc/BRIEF.md
# Programmable-Size I/O Window Select

This block watches a 12-bit host I/O address and drives an active-low select to one peripheral while the address lies inside a window. The window begins at a base address and its size comes from an 8-bit length code. In that code each single set bit picks a power-of-two size, from 1 byte for the lowest bit to 128 bytes for the highest. The window is aligned to its own size, so the base is compared only on the address bits above the size. The low bits of the base are don't-care.

The select is qualified by a read or write strobe. It is also suppressed while the address-enable qualifier is high, so that DMA cycles never decode. A length code with no bit set, or with more than one bit set, is a reserved value. It disables the decode and raises a flag.

The length code sits in a small internal register. The register resets to the 4-byte code and is loaded by a one-cycle load pulse. The select itself is combinational. A registered copy delayed by one clock is also provided for observation.

Top module: `iowin_select`

## Requirements
- R1: After reset the length register holds 8'b0000_0100, so the window is 4 bytes wide and the reserved flag is low.
- R2: When `len_ld` is high at a rising clock edge, the length register takes `len_din`, and the new size applies from that edge on.
- R3: For a length code with only bit k set, `sel_n` is low for exactly the addresses A with (base & ~(2^k-1)) <= A < (base & ~(2^k-1)) + 2^k, given a qualified cycle. It is high for every other address.
- R4: A qualified cycle is one where `io_rd_n` is low, or `io_wr_n` is low, or both are low, and `io_aen` is low. Each of these strobe combinations selects.
- R5: While `io_aen` is high, `sel_n` is high whatever the address and strobes.
- R6: While both `io_rd_n` and `io_wr_n` are high, `sel_n` is high.
- R7: A length code whose count of set bits is not exactly one (including 8'h00) holds `len_rsvd` high and `sel_n` high. For a one-hot code, `len_rsvd` is low.
- R8: `sel_n_q` equals the value `sel_n` had at the previous rising clock edge, and it is 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the length register and the registered select copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_ld | input | 1 | Load strobe for the length register |
| len_din | input | 8 | New length code |
| base_addr | input | 12 | Window base address |
| io_addr | input | 12 | Host I/O address |
| io_rd_n | input | 1 | Active-low I/O read strobe |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| io_aen | input | 1 | Address-enable qualifier; high marks a DMA cycle |
| sel_n | output | 1 | Active-low window select (combinational) |
| sel_n_q | output | 1 | `sel_n` delayed by one clock |
| len_rsvd | output | 1 | High while the length code is reserved |

## Verification
A wrong mask derived from the length code would show up right away in `sel_n`. The window would be the wrong size or shifted at its edges, so the bench probes both sides of the lower and upper boundaries for every size. A length register that loads or resets wrongly appears as a size change on the first address compared after the faulty edge. A broken delay stage shows one clock later as a mismatch between `sel_n_q` and the value of `sel_n` that the bench recorded. A reserved code that still decodes would drive `sel_n` low in the same cycle the code becomes current.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int IOW_ADDR_W = 12;
  localparam int IOW_LEN_W  = 8;

  // number of set bits in a code
  function automatic int unsigned code_pop(input logic [31:0] code);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (code[i]) n++;
    end
    return n;
  endfunction

  // exactly one bit set
  function automatic logic code_is_onehot(input logic [31:0] code);
    return code_pop(code) == 1;
  endfunction

  // mask of address bits ignored inside the window (size - 1)
  function automatic logic [31:0] code_low_mask(input logic [31:0] code);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (code[i]) m = m | ((32'd1 << i) - 32'd1);
    end
    return m;
  endfunction

endpackage

// File: rtl/iowin_lenreg.sv
module iowin_lenreg #(
  parameter int LEN_W = 8,
  parameter logic [LEN_W-1:0] RST_VAL = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [LEN_W-1:0] din,
  output logic [LEN_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ld) q <= din;
  end

  // R2
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(din));

  // R2
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/iowin_lencode.sv
module iowin_lencode
  import iowin_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [LEN_W-1:0]  len_code,
  output logic [ADDR_W-1:0] low_mask,
  output logic              rsvd
);

  logic [31:0] code_ext;
  logic [31:0] mask_full;

  assign code_ext  = 32'(len_code);
  assign mask_full = code_low_mask(code_ext);

  always_comb begin
    rsvd     = !code_is_onehot(code_ext);
    low_mask = rsvd ? '0 : mask_full[ADDR_W-1:0];
  end

endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] low_mask,
  input  logic              rsvd,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              aen,
  output logic              hit,
  output logic              cyc_ok,
  output logic              sel_n
);

  logic [ADDR_W-1:0] diff_hi;

  assign diff_hi = (addr ^ base) & ~low_mask;
  assign hit     = !rsvd && (diff_hi == '0);
  assign cyc_ok  = (!rd_n || !wr_n) && !aen;
  assign sel_n   = !(hit && cyc_ok);

endmodule

// File: rtl/iowin_select.sv
module iowin_select
  import iowin_pkg::*;
#(
  parameter int ADDR_W = IOW_ADDR_W,
  parameter int LEN_W  = IOW_LEN_W,
  parameter logic [LEN_W-1:0] LEN_RST = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_ld,
  input  logic [LEN_W-1:0]  len_din,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd_n,
  input  logic              io_wr_n,
  input  logic              io_aen,
  output logic              sel_n,
  output logic              sel_n_q,
  output logic              len_rsvd
);

  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] win_lo;
  logic              win_hit;
  logic              cyc_ok;

  iowin_lenreg #(.LEN_W(LEN_W), .RST_VAL(LEN_RST)) u_lenreg (
    .clk(clk), .rst_n(rst_n), .ld(len_ld), .din(len_din), .q(len_q)
  );

  iowin_lencode #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_lencode (
    .len_code(len_q), .low_mask(low_mask), .rsvd(len_rsvd)
  );

  iowin_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(io_addr), .base(base_addr), .low_mask(low_mask), .rsvd(len_rsvd),
    .rd_n(io_rd_n), .wr_n(io_wr_n), .aen(io_aen),
    .hit(win_hit), .cyc_ok(cyc_ok), .sel_n(sel_n)
  );

  assign win_lo = base_addr & ~low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_n_q <= 1'b1;
    else        sel_n_q <= sel_n;
  end

  // R3
  win_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> (io_addr >= win_lo) && ((io_addr - win_lo) <= low_mask));

  // R5
  aen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_aen |-> sel_n);

  // R6
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_n && io_wr_n) |-> sel_n);

  // R7
  rsvd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_rsvd |-> (sel_n && !win_hit));

  // R7
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_rsvd == ($countones(len_q) != 1));

  // R8
  reg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sel_n_q == $past(sel_n));

endmodule

// File: tb/sim_iowin_select.sv
`timescale 1ns/1ps
module sim_iowin_select;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_ld = 1'b0;
  logic [7:0]  len_din = 8'h00;
  logic [11:0] base_addr = 12'h000;
  logic [11:0] io_addr = 12'h000;
  logic        io_rd_n = 1'b1;
  logic        io_wr_n = 1'b1;
  logic        io_aen = 1'b0;
  logic        sel_n, sel_n_q, len_rsvd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] cur_code = 8'h04;

  always #2 clk = ~clk;

  iowin_select u0 (
    .clk(clk), .rst_n(rst_n), .len_ld(len_ld), .len_din(len_din),
    .base_addr(base_addr), .io_addr(io_addr), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .io_aen(io_aen), .sel_n(sel_n), .sel_n_q(sel_n_q),
    .len_rsvd(len_rsvd)
  );

  function automatic bit ref_rsvd(logic [7:0] c);
    int n = 0;
    for (int k = 0; k < 8; k++) n += c[k] ? 1 : 0;
    return n != 1;
  endfunction

  function automatic bit ref_sel_n(logic [11:0] a, logic [11:0] b, logic [7:0] c,
                                   bit rd_n, bit wr_n, bit aen);
    int size = 1;
    int lo;
    if (ref_rsvd(c) || aen || (rd_n && wr_n)) return 1'b1;
    for (int k = 0; k < 8; k++) if (c[k]) size = 1 << k;
    lo = (int'(b) / size) * size;
    return !((int'(a) >= lo) && (int'(a) < lo + size));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic load(logic [7:0] c);
    @(negedge clk);
    len_ld = 1'b1; len_din = c;
    @(posedge clk);
    cur_code = c;
    #1 len_ld = 1'b0;
  endtask

  task automatic apply(logic [11:0] a, logic [11:0] b, bit rd_n, bit wr_n,
                       bit aen, string tag);
    bit e;
    @(negedge clk);
    io_addr = a; base_addr = b; io_rd_n = rd_n; io_wr_n = wr_n; io_aen = aen;
    #1;
    e = ref_sel_n(a, b, cur_code, rd_n, wr_n, aen);
    check(sel_n == e, tag, int'(sel_n), int'(e));
    check(len_rsvd == ref_rsvd(cur_code), {tag, " rsvd flag"}, int'(len_rsvd),
          int'(ref_rsvd(cur_code)));
    @(posedge clk);
    #1;
    // R8 registered copy one edge later
    check(sel_n_q == e, "R8", int'(sel_n_q), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] b, a;
    void'($urandom(32'h5eed_0042));
    repeat (2) @(posedge clk);
    #1;
    // R8 reset value of the copy
    check(sel_n_q == 1'b1, "R8 reset", int'(sel_n_q), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset size of 4 bytes
    apply(12'h123, 12'h120, 1'b0, 1'b1, 1'b0, "R1 in");
    apply(12'h124, 12'h120, 1'b0, 1'b1, 1'b0, "R1 above");
    apply(12'h11F, 12'h120, 1'b0, 1'b1, 1'b0, "R1 below");
    check(len_rsvd == 1'b0, "R1 rsvd", int'(len_rsvd), 0);

    // R4 each strobe combination
    apply(12'h121, 12'h120, 1'b1, 1'b0, 1'b0, "R4 wr");
    apply(12'h122, 12'h120, 1'b0, 1'b0, 1'b0, "R4 both");
    // R5 DMA qualifier
    apply(12'h121, 12'h120, 1'b0, 1'b1, 1'b1, "R5");
    // R6 no strobe
    apply(12'h121, 12'h120, 1'b1, 1'b1, 1'b0, "R6");

    // R2 and R3 every size, both edges, unaligned base
    for (int k = 0; k < 8; k++) begin
      int sz = 1 << k;
      logic [11:0] lo;
      load(8'(1 << k));
      b  = 12'h3C5;
      lo = b & ~12'(sz - 1);
      apply(lo, b, 1'b0, 1'b1, 1'b0, "R3 low edge");
      apply(lo + 12'(sz - 1), b, 1'b1, 1'b0, 1'b0, "R3 high edge");
      apply(lo + 12'(sz), b, 1'b0, 1'b1, 1'b0, "R3 past end");
      apply(lo - 12'd1, b, 1'b0, 1'b1, 1'b0, "R2 before start");
    end

    // R7 reserved codes
    load(8'h00);
    apply(12'h120, 12'h120, 1'b0, 1'b1, 1'b0, "R7 zero");
    load(8'h03);
    apply(12'h120, 12'h120, 1'b0, 1'b1, 1'b0, "R7 two bits");
    load(8'hFF);
    apply(12'h000, 12'h000, 1'b0, 1'b0, 1'b0, "R7 all");
    load(8'h10);
    apply(12'h20F, 12'h200, 1'b0, 1'b1, 1'b0, "R7 back to onehot");

    // random mix
    for (int i = 0; i < 600; i++) begin
      string tag;
      bit rd_n, wr_n, aen;
      if (i % 25 == 0) begin
        if ($urandom % 4 != 0) load(8'(1 << ($urandom % 8)));
        else load(8'($urandom));
      end
      b = 12'($urandom);
      a = b + 12'($urandom % 300) - 12'd150;
      rd_n = ($urandom % 3) == 0;
      wr_n = ($urandom % 3) == 0;
      aen  = ($urandom % 8) == 0;
      if (ref_rsvd(cur_code)) tag = "R7 rand";
      else if (aen) tag = "R5 rand";
      else if (rd_n && wr_n) tag = "R6 rand";
      else tag = "R3 rand";
      apply(a, b, rd_n, wr_n, aen, tag);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule